// File: doc/BRIEF.md
# Actuated Intersection Signal Controller

This block is a synchronous controller for the signals at a five-lane road junction. Each lane has a one-bit car-presence input and a three-state lamp output. The lanes are west straight, west left, north right, north left and east. One clock cycle is taken to be one second. The controller grants right of way to one group of mutually safe lanes at a time, which is called a phase. It switches phases as demand requires and passes every lamp that loses right of way through a single Yellow cycle. It returns to the north-bound default phase when no car is waiting.

There are four phases: north pair {NL, NR} (the default, phase 0), west pair {WS, WL} (phase 1), west-straight with east {WS, E} (phase 2), and north-right with west-left {NR, WL} (phase 3). Every lane pair that does not appear together in one of these phases conflicts. A single 4-bit saturating counter times each green interval. Its only control is a clear, and it is read only through magnitude and equality comparisons. The next-state logic and the lamp decoding are separate pieces of logic.

Top module: `junction_signal_ctrl`

## Requirements
- R1: Every lamp output is a 2-bit code: Red = 0, Green = 1, Yellow = 2. The code 3 never appears.
- R2: Two lanes that share no phase are never both non-Red in the same cycle.
- R3: A lamp that leaves Green shows Yellow for exactly one cycle and then Red. A lane that belongs to both the old and the new phase stays Green through the change.
- R4: A green phase lasts at least 3 cycles before its Yellow.
- R5: While the sensor of a north-bound lane that is about to lose Green is on, the phase holds for at least 7 green cycles. If that sensor is off, the 3-cycle minimum applies.
- R6: When a car waits on a lane outside the current phase, the phase changes as soon as its minimum is met. A green phase never exceeds 10 cycles while such a car waits.
- R7: While all demand lies within the current phase, the phase stays Green for as long as it lasts, including after the counter saturates.
- R8: While reset is high, and whenever no sensor is on and the minimum is met, the controller shows the default phase: NL and NR Green and all other lamps Red.
- R9: The next phase is chosen in the cyclic order 0, 1, 2, 3 starting after the current one. It is the first phase that contains a waiting lane which is not Green now.
- R10: Every lane of the active phase is Green, whether or not its sensor is on.
- R11: Reset is synchronous. A reset during any phase shows the default phase in the next cycle, with the green timer restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per second |
| rst | input | 1 | Synchronous reset, active high |
| car_ws | input | 1 | Car present, west straight |
| car_wl | input | 1 | Car present, west left |
| car_nr | input | 1 | Car present, north right |
| car_nl | input | 1 | Car present, north left |
| car_e | input | 1 | Car present, east |
| lamp_ws | output | 2 | Lamp, west straight |
| lamp_wl | output | 2 | Lamp, west left |
| lamp_nr | output | 2 | Lamp, north right |
| lamp_nl | output | 2 | Lamp, north left |
| lamp_e | output | 2 | Lamp, east |

## Verification
The hardest situation to reach from the ports is a full rotation through all four phases. Only then do the yellow cycles occur in which a shared lane stays Green, such as west straight from phase 1 to phase 2 and north right from phase 3 to phase 0. Each phase is also held for its own minimum, 3 or 7 cycles. The stimulus reaches this by holding every sensor on from the west pair, so the round-robin order walks through phases 2, 3, 0 and back to 1. Before that, a sensor drop in the middle of a north green shows the hold shrinking from 7 cycles to 3.

// File: rtl/sig_pkg.sv
package sig_pkg;

    localparam int NLANE  = 5;
    localparam int NPHASE = 4;

    // lane positions inside every lane vector
    localparam int L_WS = 0;
    localparam int L_WL = 1;
    localparam int L_NR = 2;
    localparam int L_NL = 3;
    localparam int L_E  = 4;

    typedef logic [NLANE-1:0] lanes_t;
    typedef logic [1:0]       phase_t;

    typedef enum logic [1:0] {
        LAMP_RED    = 2'd0,
        LAMP_GREEN  = 2'd1,
        LAMP_YELLOW = 2'd2
    } lamp_e;

    typedef enum logic {
        M_GREEN  = 1'b0,
        M_YELLOW = 1'b1
    } mode_e;

    typedef struct packed {
        phase_t phase;   // phase currently holding right of way
        phase_t target;  // phase that follows the yellow cycle
        mode_e  mode;
    } ctl_s;

    localparam phase_t PH_DEFAULT = 2'd0;
    localparam lanes_t NORTH_LANES = lanes_t'((1 << L_NR) | (1 << L_NL));

    function automatic lanes_t phase_lanes(input phase_t p);
        lanes_t m;
        m = '0;
        case (p)
            2'd0: begin m[L_NL] = 1'b1; m[L_NR] = 1'b1; end
            2'd1: begin m[L_WS] = 1'b1; m[L_WL] = 1'b1; end
            2'd2: begin m[L_WS] = 1'b1; m[L_E]  = 1'b1; end
            default: begin m[L_NR] = 1'b1; m[L_WL] = 1'b1; end
        endcase
        return m;
    endfunction

    // two lanes are safe together when some phase carries both
    function automatic logic lanes_compatible(input int a, input int b);
        logic ok;
        ok = 1'b0;
        for (int p = 0; p < NPHASE; p++) begin
            if (phase_lanes(phase_t'(p))[a] && phase_lanes(phase_t'(p))[b])
                ok = 1'b1;
        end
        return ok;
    endfunction

endpackage

// File: rtl/green_timer.sv
module green_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_q, count_d;

    always_comb begin
        if (clr)
            count_d = '0;
        else if (count_q == TOP)
            count_d = count_q;
        else
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/phase_picker.sv
module phase_picker
    import sig_pkg::*;
(
    input  phase_t cur,
    input  lanes_t waiting,
    output phase_t pick
);
    always_comb begin
        lanes_t cur_m;
        phase_t cand;
        cur_m = phase_lanes(cur);
        pick  = cur;
        // scan from farthest to nearest so the nearest candidate wins
        for (int off = NPHASE - 1; off >= 1; off--) begin
            cand = phase_t'(int'(cur) + off);
            if (|(waiting & phase_lanes(cand) & ~cur_m))
                pick = cand;
        end
    end
endmodule

// File: rtl/lamp_driver.sv
module lamp_driver
    import sig_pkg::*;
(
    input  ctl_s                  st,
    output logic [NLANE-1:0][1:0] lamps
);
    lanes_t cur_m, tgt_m;

    assign cur_m = phase_lanes(st.phase);
    assign tgt_m = phase_lanes(st.target);

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        always_comb begin
            if (!cur_m[i])
                lamps[i] = LAMP_RED;
            else if (st.mode == M_GREEN || tgt_m[i])
                lamps[i] = LAMP_GREEN;
            else
                lamps[i] = LAMP_YELLOW;
        end
    end
endmodule

// File: rtl/junction_signal_ctrl.sv
module junction_signal_ctrl
    import sig_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int MIN_G    = 3,
    parameter int NB_MIN_G = 7,
    parameter int MAX_G    = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       car_ws,
    input  logic       car_wl,
    input  logic       car_nr,
    input  logic       car_nl,
    input  logic       car_e,
    output logic [1:0] lamp_ws,
    output logic [1:0] lamp_wl,
    output logic [1:0] lamp_nr,
    output logic [1:0] lamp_nl,
    output logic [1:0] lamp_e
);
    localparam logic [CNT_W-1:0] MIN_TH    = (CNT_W)'(MIN_G - 1);
    localparam logic [CNT_W-1:0] NB_MIN_TH = (CNT_W)'(NB_MIN_G - 1);
    localparam logic [CNT_W-1:0] MAX_TH    = (CNT_W)'(MAX_G - 1);

    ctl_s              st_q, st_d;
    logic              clr_d;
    logic [CNT_W-1:0]  gcnt;
    lanes_t            dem, cur_m, drop_m;
    phase_t            rr_pick, goal;
    logic              other_wait, idle, want_change, north_hold, min_ok;
    logic [NLANE-1:0][1:0] lamps;

    assign dem = {car_e, car_nl, car_nr, car_wl, car_ws};

    green_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .clr   (clr_d),
        .count (gcnt)
    );

    phase_picker i_picker (
        .cur     (st_q.phase),
        .waiting (dem),
        .pick    (rr_pick)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        cur_m       = phase_lanes(st_q.phase);
        other_wait  = |(dem & ~cur_m);
        idle        = (dem == '0);
        goal        = other_wait ? rr_pick : PH_DEFAULT;
        drop_m      = cur_m & ~phase_lanes(goal);
        north_hold  = |(drop_m & dem & NORTH_LANES);
        min_ok      = (gcnt > MIN_TH || gcnt == MIN_TH) &&
                      (!north_hold || gcnt > NB_MIN_TH || gcnt == NB_MIN_TH);
        want_change = other_wait || (idle && st_q.phase != PH_DEFAULT);

        st_d  = st_q;
        clr_d = 1'b0;
        if (rst) begin
            st_d.phase  = PH_DEFAULT;
            st_d.target = PH_DEFAULT;
            st_d.mode   = M_GREEN;
            clr_d       = 1'b1;
        end else begin
            case (st_q.mode)
                M_GREEN: begin
                    if (want_change && min_ok) begin
                        st_d.target = goal;
                        st_d.mode   = M_YELLOW;
                    end
                end
                default: begin
                    st_d.phase = st_q.target;
                    st_d.mode  = M_GREEN;
                    clr_d      = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // ---------------- output logic ----------------
    lamp_driver i_lamps (
        .st    (st_q),
        .lamps (lamps)
    );

    assign lamp_ws = lamps[L_WS];
    assign lamp_wl = lamps[L_WL];
    assign lamp_nr = lamps[L_NR];
    assign lamp_nl = lamps[L_NL];
    assign lamp_e  = lamps[L_E];

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] run_q [NLANE];

    for (genvar i = 0; i < NLANE; i++) begin : g_chk
        always_ff @(posedge clk) begin
            if (rst || lamps[i] != LAMP_GREEN)
                run_q[i] <= '0;
            else if (run_q[i] != '1)
                run_q[i] <= run_q[i] + 1'b1;
        end

        p_code_valid_r1: assert property (@(posedge clk) disable iff (rst)
            lamps[i] != 2'd3);

        p_yellow_one_r3: assert property (@(posedge clk) disable iff (rst)
            lamps[i] == LAMP_YELLOW |=> lamps[i] == LAMP_RED);

        p_no_skip_r3: assert property (@(posedge clk) disable iff (rst)
            lamps[i] == LAMP_GREEN |=> lamps[i] != LAMP_RED);

        p_min_green_r4: assert property (@(posedge clk) disable iff (rst)
            (lamps[i] == LAMP_GREEN && run_q[i] < MIN_TH) |=> lamps[i] == LAMP_GREEN);

        if (NORTH_LANES[i]) begin : g_north
            p_north_min_r5: assert property (@(posedge clk) disable iff (rst)
                (lamps[i] == LAMP_GREEN && dem[i] && run_q[i] < NB_MIN_TH)
                |=> lamps[i] == LAMP_GREEN);
        end

        for (genvar j = i + 1; j < NLANE; j++) begin : g_pair
            if (!lanes_compatible(i, j)) begin : g_conf
                p_no_conflict_r2: assert property (@(posedge clk) disable iff (rst)
                    !(lamps[i] != LAMP_RED && lamps[j] != LAMP_RED));
            end
        end
    end

    p_max_green_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_GREEN && other_wait && (gcnt > MAX_TH || gcnt == MAX_TH))
        |=> st_q.mode == M_YELLOW);

    p_reset_default_r8: assert property (@(posedge clk)
        rst |=> (lamp_nl == LAMP_GREEN && lamp_nr == LAMP_GREEN &&
                 lamp_ws == LAMP_RED && lamp_wl == LAMP_RED && lamp_e == LAMP_RED));

    p_reset_timer_r11: assert property (@(posedge clk)
        rst |=> gcnt == '0);
endmodule

// File: tb/test_junction_signal_ctrl.sv
module test_junction_signal_ctrl;

    localparam logic [1:0] R = 2'd0;
    localparam logic [1:0] G = 2'd1;
    localparam logic [1:0] Y = 2'd2;

    // sensor vector order {e, nl, nr, wl, ws}
    localparam logic [4:0] S_WS  = 5'b00001;
    localparam logic [4:0] S_NL  = 5'b01000;
    localparam logic [4:0] S_E   = 5'b10000;
    localparam logic [4:0] S_ALL = 5'b11111;

    typedef struct {
        logic [9:0] exp;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] sens = '0;
    logic [1:0] l_ws, l_wl, l_nr, l_nl, l_e;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t q[$];

    always #4 clk = ~clk;

    junction_signal_ctrl i_junction_signal_ctrl (
        .clk(clk), .rst(rst),
        .car_ws(sens[0]), .car_wl(sens[1]), .car_nr(sens[2]),
        .car_nl(sens[3]), .car_e(sens[4]),
        .lamp_ws(l_ws), .lamp_wl(l_wl), .lamp_nr(l_nr),
        .lamp_nl(l_nl), .lamp_e(l_e)
    );

    function automatic logic [9:0] pat(input logic [1:0] ws, wl, nr, nl, e);
        return {e, nl, nr, wl, ws};
    endfunction

    // safe pairs, written from the phase list
    function automatic bit safe_pair(input int a, input int b);
        int lo, hi;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        return (lo == 2 && hi == 3) || (lo == 0 && hi == 1) ||
               (lo == 0 && hi == 4) || (lo == 1 && hi == 2);
    endfunction

    task automatic step(input logic [4:0] s, input logic r, input logic [9:0] e,
                        input string tag);
        item_t it;
        @(negedge clk);
        sens = s;
        rst  = r;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic hold(input logic [4:0] s, input int n, input logic [9:0] e,
                        input string tag);
        for (int k = 0; k < n; k++) step(s, 1'b0, e, tag);
    endtask

    // monitor: pops one expected pattern per cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [9:0] got;
                logic [1:0] lv [5];
                it  = q.pop_front();
                got = pat(l_ws, l_wl, l_nr, l_nl, l_e);
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: lamps %h expected %h", it.tag, got, it.exp);
                end
                lv = '{l_ws, l_wl, l_nr, l_nl, l_e};
                checks++;
                for (int a = 0; a < 5; a++) begin
                    for (int b = a + 1; b < 5; b++) begin
                        if (!safe_pair(a, b) && lv[a] != R && lv[b] != R) begin
                            errors++;
                            $display("FAIL R2: lanes %0d,%0d both active, got %h expected no conflict",
                                     a, b, got);
                        end
                    end
                end
            end
        end
    end

    initial begin
        logic [9:0] p0g, p1g, p2g, p3g, y01, y10, y12, y23, y30;
        p0g = pat(R, R, G, G, R);
        p1g = pat(G, G, R, R, R);
        p2g = pat(G, R, R, R, G);
        p3g = pat(R, G, G, R, R);
        y01 = pat(R, R, Y, Y, R);
        y10 = pat(Y, Y, R, R, R);
        y12 = pat(G, Y, R, R, R);
        y23 = pat(Y, R, R, R, Y);
        y30 = pat(R, Y, G, R, R);

        for (int k = 0; k < 3; k++) step(S_ALL, 1'b1, p0g, "R8 reset default, R1 codes");
        hold(5'b0, 3, p0g, "R8 idle default");
        // west straight alone
        step(S_WS, 1'b0, y01, "R3 north yellow");
        hold(S_WS, 15, p1g, "R7 hold past saturation, R10 west left lit");
        // contention west straight vs north left
        step(S_WS | S_NL, 1'b0, y10, "R3 west yellow");
        hold(S_WS | S_NL, 7, p0g, "R5 north held 7");
        step(S_WS | S_NL, 1'b0, y01, "R5 release after 7");
        hold(S_WS | S_NL, 3, p1g, "R4 R6 switch at minimum");
        step(S_WS | S_NL, 1'b0, y10, "R6 hand-off");
        step(S_WS | S_NL, 1'b0, p0g, "R9 back to north");
        // north sensor drops
        hold(S_WS, 2, p0g, "R5 drop keeps 3 minimum");
        step(S_WS, 1'b0, y01, "R5 early release");
        hold(S_WS, 2, p1g, "R10 west pair");
        // full rotation
        step(S_ALL, 1'b0, p1g, "R4 minimum");
        step(S_ALL, 1'b0, y12, "R3 shared west straight stays");
        hold(S_ALL, 3, p2g, "R9 phase 2");
        step(S_ALL, 1'b0, y23, "R3 phase 2 yellow");
        hold(S_ALL, 3, p3g, "R9 phase 3");
        step(S_ALL, 1'b0, y30, "R3 shared north right stays");
        hold(S_ALL, 7, p0g, "R5 R9 phase 0");
        step(S_ALL, 1'b0, y01, "R3 north yellow");
        step(S_ALL, 1'b0, p1g, "R9 phase 1");
        // demand vanishes
        hold(5'b0, 2, p1g, "R4 minimum before idle");
        step(5'b0, 1'b0, y10, "R3 to idle");
        hold(5'b0, 2, p0g, "R8 idle return");
        // east alone
        step(S_E, 1'b0, p0g, "R4 minimum");
        step(S_E, 1'b0, y01, "R3 to east");
        hold(S_E, 5, p2g, "R7 east held, R10 west straight lit");
        // reset during a green
        step(S_E, 1'b1, p0g, "R11 reset mid phase");
        hold(S_E, 2, p0g, "R11 timer restarted");

        @(posedge clk);
        #4;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule